// File: doc/BRIEF.md
# EEPROM Page-Write Collector and Commit Sequencer

This block sits between a two-wire protocol engine and a nonvolatile memory array. During a write transaction it collects incoming data bytes into a one-page staging buffer. Each slot of the buffer has its own valid bit. When the protocol engine reports the end of the transaction, the block programs every slot that received data into the array. All of these writes happen inside one fixed-length busy interval.

The protocol engine supplies three things: a one-cycle strobe carrying the start address (the word-address phase), one strobe for each data byte, and one strobe for the stop condition. The block keeps only the in-page offset moving. Once the last slot of a page is filled, the offset wraps back to the first slot of the same page, so a long burst overwrites bytes received earlier. A write-protect level, sampled at the stop, can cancel the whole commit.

The block drives a simple memory write port, a busy flag, and the shared address pointer. A read engine uses that pointer for current-address reads.

Top module: `pgwr_sequencer`

## Requirements
- R1: A start-address strobe (`load_addr_i`) sets the page base to the upper address bits and the in-page offset to the low PAGE_W bits. The `ptr_o` output shows the full start address one cycle later. Any bytes already buffered are discarded.
- R2: Each data strobe stores its byte at the current offset and then advances the offset by one, modulo 2^PAGE_W (16 by default). The page base bits never change. After offset 15 comes offset 0 of the same page.
- R3: When more bytes arrive than a page holds, a later byte replaces the earlier byte in the same slot. Only the final value of each slot is programmed.
- R4: Only slots that received data are written to the array. A commit produces exactly one `mem_we_o` pulse per distinct slot filled.
- R5: The array is not written before the stop strobe. A stop that finds at least one buffered byte, with `wp_i` low, raises `busy_o` in the next cycle. `busy_o` then stays high for exactly WR_TICKS cycles (at least 2^PAGE_W), and every array write falls within that window.
- R6: While `busy_o` is high, address, data and stop strobes are ignored. They change neither the buffer nor `ptr_o`.
- R7: If `wp_i` is high when the stop strobe arrives, no array write happens and `busy_o` stays low. The buffered bytes are discarded.
- R8: A stop strobe with no buffered bytes starts no busy interval.
- R9: When the busy interval ends, the block returns to idle. `ptr_o` then holds the page base joined to the offset of the last byte received.
- R10: After reset, `busy_o` and `mem_we_o` are low, `ptr_o` is zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_addr_i | input | 1 | Start-address strobe |
| start_addr_i | input | ADDR_W | Start address that goes with the strobe |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop-condition strobe |
| wp_i | input | 1 | Write-protect level, sampled with the stop strobe |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Programming interval in progress |
| ptr_o | output | ADDR_W | Shared address pointer |

## Verification
The assertions assume that the protocol engine raises at most one of its three strobes in any given cycle. They also assume that each strobe lasts exactly one cycle. Under that assumption the priority among simultaneous strobes never matters. The stimulus keeps to this rule: it drives each strobe for a single cycle on the falling edge and clears it before the next one. Random transactions use random start addresses, burst lengths from zero to forty bytes, and occasional protected stops. Strobes that arrive during a busy interval are applied deliberately, each one separately, to exercise the ignore rule.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_PROG = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              any_o
);
    localparam int SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             mask;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr_i) begin
            buf_d.mask = '0;
        end
        if (wr_i) begin
            buf_d.data[wr_idx_i] = wr_data_i;
            buf_d.mask[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_data_o = buf_q.data[rd_idx_i];
    assign rd_vld_o  = buf_q.mask[rd_idx_i];
    assign any_o     = |buf_q.mask;

    // A stored byte lands in its slot and marks it valid (R2, R3)
    assert_slot_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> buf_q.mask[$past(wr_idx_i)] && (buf_q.data[$past(wr_idx_i)] == $past(wr_data_i)));

    // Clearing without a new byte leaves the buffer empty (R1, R7)
    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> !any_o);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int TICKS = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;
    assign cnt_o  = tmr_q.cnt;
    assign done_o = tmr_q.busy && (tmr_q.cnt == LAST);

    assert_start_raises_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_done_drops_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic                     busy_i,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic [ADDR_W-PAGE_W-1:0] base_i,
    input  logic [DATA_W-1:0]        slot_data_i,
    input  logic                     slot_vld_i,
    output logic [PAGE_W-1:0]        slot_idx_o,
    output logic                     we_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [DATA_W-1:0]        data_o
);
    localparam int SLOTS = 1 << PAGE_W;
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(SLOTS);

    logic in_scan;

    always_comb begin
        in_scan    = busy_i && (cnt_i < SCAN_END);
        slot_idx_o = cnt_i[PAGE_W-1:0];
        we_o       = in_scan && slot_vld_i;
        addr_o     = {base_i, slot_idx_o};
        data_o     = slot_data_i;
    end
endmodule

// File: rtl/pgwr_sequencer.sv
module pgwr_sequencer #(
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WR_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] ptr_o
);
    import pgwr_pkg::*;

    localparam int SLOTS      = 1 << PAGE_W;
    localparam int BASE_W     = ADDR_W - PAGE_W;
    localparam int PROG_TICKS = (WR_TICKS < SLOTS) ? SLOTS : WR_TICKS;
    localparam int CNT_W      = $clog2(PROG_TICKS) + 1;

    typedef struct packed {
        seq_state_e         state;
        logic [BASE_W-1:0]  base;
        logic [PAGE_W-1:0]  off;
        logic [PAGE_W-1:0]  last_off;
        logic [ADDR_W-1:0]  ptr;
    } seq_t;

    seq_t st_d, st_q;

    logic              buf_clr, buf_wr, buf_any, slot_vld;
    logic [DATA_W-1:0] slot_data;
    logic [PAGE_W-1:0] slot_idx;
    logic              tmr_start, tmr_busy, tmr_done;
    logic [CNT_W-1:0]  tmr_cnt;

    always_comb begin
        st_d      = st_q;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        tmr_start = 1'b0;
        case (st_q.state)
            SEQ_IDLE: begin
                if (load_addr_i) begin
                    st_d.base = start_addr_i[ADDR_W-1:PAGE_W];
                    st_d.off  = start_addr_i[PAGE_W-1:0];
                    st_d.ptr  = start_addr_i;
                    buf_clr   = 1'b1;
                end else if (byte_vld_i) begin
                    buf_wr        = 1'b1;
                    st_d.last_off = st_q.off;
                    st_d.off      = st_q.off + 1'b1;
                end else if (stop_i) begin
                    if (buf_any && !wp_i) begin
                        st_d.state = SEQ_PROG;
                        tmr_start  = 1'b1;
                    end else begin
                        buf_clr = 1'b1;
                    end
                end
            end
            SEQ_PROG: begin
                if (tmr_done) begin
                    st_d.state = SEQ_IDLE;
                    st_d.ptr   = {st_q.base, st_q.last_off};
                    buf_clr    = 1'b1;
                end
            end
            default: st_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SEQ_IDLE, base: '0, off: '0, last_off: '0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    pgwr_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_i      (buf_wr),
        .wr_idx_i  (st_q.off),
        .wr_data_i (byte_data_i),
        .rd_idx_i  (slot_idx),
        .rd_data_o (slot_data),
        .rd_vld_o  (slot_vld),
        .any_o     (buf_any)
    );

    pgwr_timer #(.TICKS(PROG_TICKS), .CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done),
        .cnt_o   (tmr_cnt)
    );

    pgwr_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_commit (
        .busy_i      (tmr_busy),
        .cnt_i       (tmr_cnt),
        .base_i      (st_q.base),
        .slot_data_i (slot_data),
        .slot_vld_i  (slot_vld),
        .slot_idx_o  (slot_idx),
        .we_o        (mem_we_o),
        .addr_o      (mem_addr_o),
        .data_o      (mem_wdata_o)
    );

    assign busy_o = tmr_busy;
    assign ptr_o  = st_q.ptr;

    // Strobes during the busy interval leave page state and pointer alone
    assert_frozen_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tmr_done) |=> $stable(st_q.base) && $stable(st_q.last_off) && $stable(ptr_o));

    // A protected stop never opens a programming interval
    assert_wp_blocks_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i && !load_addr_i && !byte_vld_i) |=> !busy_o);

    // A stop with nothing buffered opens no interval
    assert_empty_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !buf_any && !load_addr_i && !byte_vld_i) |=> !busy_o);

    // After the interval the buffer is empty and the sequencer idle
    assert_commit_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!buf_any && st_q.state == SEQ_IDLE));
endmodule

// File: tb/pgwr_sequencer_bench.sv
`timescale 1ns/1ps
module pgwr_sequencer_bench;
    localparam int ADDR_W = 10;
    localparam int PAGE_W = 4;
    localparam int DATA_W = 8;
    localparam int TICKS  = 40;
    localparam int SLOTS  = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_addr_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic              byte_vld_i = 1'b0;
    logic [DATA_W-1:0] byte_data_i = '0;
    logic              stop_i = 1'b0;
    logic              wp_i = 1'b0;
    logic              mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic              busy_o;
    logic [ADDR_W-1:0] ptr_o;

    pgwr_sequencer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .WR_TICKS(TICKS))
    u_pgwr_sequencer (
        .clk(clk), .rst_n(rst_n), .load_addr_i(load_addr_i), .start_addr_i(start_addr_i),
        .byte_vld_i(byte_vld_i), .byte_data_i(byte_data_i), .stop_i(stop_i), .wp_i(wp_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .busy_o(busy_o), .ptr_o(ptr_o)
    );

    always #2 clk = ~clk;

    logic [DATA_W-1:0] tb_mem  [DEPTH];
    logic [DATA_W-1:0] exp_mem [DEPTH];
    int n_wr = 0;
    int n_busy = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            tb_mem[i]  = '0;
            exp_mem[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (mem_we_o) begin
            tb_mem[mem_addr_o] <= mem_wdata_o;
            n_wr <= n_wr + 1;
        end
        if (busy_o) n_busy <= n_busy + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mem_mismatch();
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) if (tb_mem[i] !== exp_mem[i]) bad++;
        return bad;
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] a, input int i);
        return {a[ADDR_W-1:PAGE_W], PAGE_W'((int'(a[PAGE_W-1:0]) + i) % SLOTS)};
    endfunction

    // One write transaction; poke=1 throws strobes at the block while busy
    task automatic txn(input logic [ADDR_W-1:0] addr, input int n, input bit wp, input bit poke);
        logic [DATA_W-1:0] sd [SLOTS];
        bit sv [SLOTS];
        int filled = 0;
        int w0, b0, last;
        bit commit;
        logic [ADDR_W-1:0] exp_ptr;
        for (int s = 0; s < SLOTS; s++) begin sv[s] = 1'b0; sd[s] = '0; end
        last = int'(addr[PAGE_W-1:0]);

        load_addr_i = 1'b1; start_addr_i = addr;
        @(negedge clk); load_addr_i = 1'b0;
        chk(ptr_o == addr, "R1", "pointer after address strobe", int'(ptr_o), int'(addr));

        w0 = n_wr;
        for (int i = 0; i < n; i++) begin
            logic [DATA_W-1:0] d = DATA_W'($urandom);
            int s = (int'(addr[PAGE_W-1:0]) + i) % SLOTS;
            byte_vld_i = 1'b1; byte_data_i = d;
            sd[s] = d; sv[s] = 1'b1; last = s;
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        for (int s = 0; s < SLOTS; s++) if (sv[s]) filled++;
        chk(n_wr == w0, "R5", "writes before stop", n_wr - w0, 0);

        commit = (n > 0) && !wp;
        b0 = n_busy;
        wp_i = wp; stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0; wp_i = 1'b0;
        chk(busy_o == commit, commit ? "R5" : (wp ? "R7" : "R8"), "busy after stop", int'(busy_o), int'(commit));

        if (commit) begin
            for (int s = 0; s < SLOTS; s++)
                if (sv[s]) exp_mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(s)}] = sd[s];
            exp_ptr = {addr[ADDR_W-1:PAGE_W], PAGE_W'(last)};
        end else begin
            exp_ptr = addr;
        end

        if (poke && commit) begin
            load_addr_i = 1'b1; start_addr_i = addr ^ 10'h2A5;
            @(negedge clk); load_addr_i = 1'b0;
            byte_vld_i = 1'b1; byte_data_i = 8'hEE;
            @(negedge clk); byte_vld_i = 1'b0;
            stop_i = 1'b1;
            @(negedge clk); stop_i = 1'b0;
        end
        repeat (TICKS + 3) @(negedge clk);

        chk(!busy_o, "R9", "busy cleared after interval", int'(busy_o), 0);
        chk(n_busy - b0 == (commit ? TICKS : 0), "R5", "busy cycle count", n_busy - b0, commit ? TICKS : 0);
        chk(n_wr - w0 == (commit ? filled : 0), "R4", "write pulses", n_wr - w0, commit ? filled : 0);
        chk(mem_mismatch() == 0, n > SLOTS ? "R3" : "R2", "array bytes differing", mem_mismatch(), 0);
        chk(ptr_o == exp_ptr, poke ? "R6" : "R9", "pointer after transaction", int'(ptr_o), int'(exp_ptr));

        if (poke || wp) begin
            // Any byte that slipped into the buffer would make this stop commit
            b0 = n_busy;
            stop_i = 1'b1;
            @(negedge clk); stop_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(n_busy == b0, poke ? "R6" : "R7", "stale bytes after ignored/discarded data", n_busy - b0, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk); @(negedge clk);
        chk(!busy_o && !mem_we_o, "R10", "busy/we during reset", int'(busy_o) + int'(mem_we_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ptr_o == '0, "R10", "pointer after reset", int'(ptr_o), 0);
        chk(!busy_o, "R10", "busy after reset", int'(busy_o), 0);

        txn(10'h120, 1, 1'b0, 1'b0);   // single byte
        txn(10'h2AE, 4, 1'b0, 1'b0);   // wraps past offset 15 (R2)
        txn(10'h305, 3, 1'b0, 1'b0);   // partial page (R4)
        txn(10'h043, 20, 1'b0, 1'b0);  // overflow overwrites (R3)
        txn(10'h050, 16, 1'b0, 1'b0);  // full page exactly
        txn(10'h3F0, 5, 1'b1, 1'b0);   // protected (R7)
        txn(10'h111, 0, 1'b0, 1'b0);   // empty stop (R8)
        txn(10'h1C7, 6, 1'b0, 1'b1);   // strobes during busy (R6)

        for (int k = 0; k < 30; k++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            int n = int'($urandom % 41);
            bit wp = ($urandom % 5) == 0;
            bit pk = ($urandom % 4) == 0;
            txn(a, n, wp, pk);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule